// File: doc/BRIEF.md
# Framed 16-Bit Serial Word Transmitter

This block is a transmit-only serial master. It delivers 16-bit command words to a peripheral over three wires: a frame-select line, a serial clock and a data line. A host offers a word with a valid/ready handshake. The block then asserts frame-select, clocks the 16 bits out with the most significant bit first, and releases frame-select. The receiver captures each bit on a falling clock edge, so the data line changes only when the clock rises. The word is laid out as a 4-bit control nibble on top, then a 4-bit address nibble, then an 8-bit data byte.

Two options cover hosts that send in bytes. In split mode the word leaves as two bursts of eight clock pulses each. Between the bursts the clock idles high for a programmable number of system cycles, and frame-select stays asserted throughout. In reversed-byte mode the host supplies each byte LSB-first, and the block mirrors each byte so that the wire still carries MSB first. A polarity option inverts the frame-select pin for receivers that expect an active-high frame. The half-period of the serial clock is programmable in system cycles.

Top module: `fsync_word_tx`

## Requirements
- R1: While reset is held and in the cycle after it, `in_ready` is 1, `sclk_o` is 1, `sdata_o` is 0 and frame-select is inactive (`fsync_o` equals the inverse of `cfg_fs_inv`).
- R2: Each accepted word produces one contiguous active frame-select period containing exactly 16 falling `sclk_o` edges. Frame-select becomes active before the first fall and returns inactive only after the sixteenth.
- R3: With `cfg_lsb_first`=0, the bits present on `sdata_o` at the sixteen falling edges are `in_word[15]` down to `in_word[0]`, in that order.
- R4: Each sclk high and low phase lasts H system cycles, where H = `cfg_half` (a value of 0 acts as 1). After frame-select becomes active, the clock stays high for H cycles before the first fall.
- R5: `sdata_o` never changes while `sclk_o` stays low across consecutive cycles. It changes only in cycles where the clock has just risen or is high.
- R6: With `cfg_split`=1, the clock stays high for `cfg_gap`+H cycles between falls 8 and 9, and frame-select stays active through that gap. Without split, or with `cfg_gap`=0, that interval is H like any other.
- R7: With `cfg_lsb_first`=1, the wire carries `{rev(in_word[15:8]), rev(in_word[7:0])}` MSB-first. Here rev mirrors the bits of a byte.
- R8: Frame-select is active low when `cfg_fs_inv`=0 and active high when `cfg_fs_inv`=1. The idle level follows the same inversion.
- R9: `in_ready` is 0 from the cycle after acceptance until frame-select has been inactive for at least 2H cycles. No new frame starts sooner than that.
- R10: While frame-select is inactive, `sclk_o` is 1 and `sdata_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_half | input | DIV_W | Serial clock half-period in system cycles (0 acts as 1), sampled at acceptance |
| cfg_gap | input | GAP_W | Extra inter-burst idle cycles in split mode, sampled at acceptance |
| cfg_split | input | 1 | Send the word as two 8-pulse bursts |
| cfg_lsb_first | input | 1 | Host supplies bytes LSB-first; mirror each byte |
| cfg_fs_inv | input | 1 | Invert the frame-select pin |
| in_valid | input | 1 | Host offers a word |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 16 | Word: control nibble, address nibble, data byte |
| sclk_o | output | 1 | Serial clock, idles high |
| sdata_o | output | 1 | Serial data |
| fsync_o | output | 1 | Frame-select, active low unless inverted |

## Verification
The hardest situation to reach is the boundary between the two bursts of a split word. The receiver has to see frame-select still asserted and the clock parked high for exactly the programmed gap plus one half-period. A gap of zero must collapse to an ordinary half-period. The bench reaches this by walking split vectors with gaps of 0, 1, 5 and 12 through a decoder of the wire. The decoder measures every high and low run between falls. A second hard case is the recovery guard between frames. A word is offered the instant ready returns, and the length of the inactive frame-select interval is then measured.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;
    localparam int BIT_W  = $clog2(WORD_W);

    // Word layout: control on top, address next, data byte at the bottom.
    typedef struct packed {
        logic [3:0]        ctl;
        logic [3:0]        addr;
        logic [BYTE_W-1:0] data;
    } fsw_word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_GAP,
        ST_TAIL,
        ST_GUARD
    } fsw_state_e;

    function automatic logic [BYTE_W-1:0] fsw_mirror(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) begin
            r[i] = b[BYTE_W-1-i];
        end
        return r;
    endfunction

    // Order in which the word leaves the shifter, MSB first on the wire.
    function automatic logic [WORD_W-1:0] fsw_wire_order(input fsw_word_t w,
                                                         input logic      mirror);
        logic [WORD_W-1:0] raw;
        raw = w;
        if (mirror) begin
            return {fsw_mirror(raw[WORD_W-1:BYTE_W]), fsw_mirror(raw[BYTE_W-1:0])};
        end
        return raw;
    endfunction

endpackage

// File: rtl/fsw_timer.sv
module fsw_timer #(
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - CNT_W'(1);
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/fsw_shifter.sv
module fsw_shifter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb
);

    logic [W-1:0] sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr <= '0;
        end else if (load) begin
            sr <= load_word;
        end else if (shift) begin
            sr <= {sr[W-2:0], 1'b0};
        end
    end

    assign msb = sr[W-1];

endmodule

// File: rtl/fsw_ctrl.sv
module fsw_ctrl
    import fsw_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic             cfg_split,
    input  logic             tmr_done,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output logic             sh_load,
    output logic             sh_shift,
    output logic             fs_act,
    output logic             sclk
);

    localparam logic [BIT_W-1:0] LAST_BIT  = BIT_W'(WORD_W - 1);
    localparam logic [BIT_W-1:0] SPLIT_BIT = BIT_W'(BYTE_W - 1);

    fsw_state_e       state, state_nx;
    logic [BIT_W-1:0] bit_idx;
    logic [DIV_W-1:0] half_q;
    logic [GAP_W-1:0] gap_q;
    logic             split_q;

    logic [CNT_W-1:0] h_live, h_lat, half_m1, guard_m1, gap_m1, h_start_m1;

    always_comb begin
        h_live     = (cfg_half == '0) ? CNT_W'(1) : CNT_W'(cfg_half);
        h_lat      = (half_q == '0) ? CNT_W'(1) : CNT_W'(half_q);
        h_start_m1 = h_live - CNT_W'(1);
        half_m1    = h_lat - CNT_W'(1);
        guard_m1   = (h_lat << 1) - CNT_W'(1);
        gap_m1     = CNT_W'(gap_q) - CNT_W'(1);
    end

    always_comb begin
        state_nx = state;
        tmr_load = 1'b0;
        tmr_val  = half_m1;
        sh_load  = 1'b0;
        sh_shift = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin
                    state_nx = ST_LEAD;
                    tmr_load = 1'b1;
                    tmr_val  = h_start_m1;
                    sh_load  = 1'b1;
                end
            end
            ST_LEAD, ST_HIGH: begin
                if (tmr_done) begin
                    state_nx = ST_LOW;
                    tmr_load = 1'b1;
                end
            end
            ST_LOW: begin
                if (tmr_done) begin
                    tmr_load = 1'b1;
                    if (bit_idx == LAST_BIT) begin
                        state_nx = ST_TAIL;
                    end else begin
                        sh_shift = 1'b1;
                        if (split_q && bit_idx == SPLIT_BIT && gap_q != '0) begin
                            state_nx = ST_GAP;
                            tmr_val  = gap_m1;
                        end else begin
                            state_nx = ST_HIGH;
                        end
                    end
                end
            end
            ST_GAP: begin
                if (tmr_done) begin
                    state_nx = ST_HIGH;
                    tmr_load = 1'b1;
                end
            end
            ST_TAIL: begin
                if (tmr_done) begin
                    state_nx = ST_GUARD;
                    tmr_load = 1'b1;
                    tmr_val  = guard_m1;
                end
            end
            ST_GUARD: begin
                if (tmr_done) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            half_q  <= '0;
            gap_q   <= '0;
            split_q <= 1'b0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && in_valid) begin
                bit_idx <= '0;
                half_q  <= cfg_half;
                gap_q   <= cfg_gap;
                split_q <= cfg_split;
            end else if (sh_shift) begin
                bit_idx <= bit_idx + BIT_W'(1);
            end
        end
    end

    assign in_ready = (state == ST_IDLE);
    assign fs_act   = (state != ST_IDLE) && (state != ST_GUARD);
    assign sclk     = (state != ST_LOW);

endmodule

// File: rtl/fsync_word_tx.sv
module fsync_word_tx
    import fsw_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DIV_W-1:0]  cfg_half,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              cfg_split,
    input  logic              cfg_lsb_first,
    input  logic              cfg_fs_inv,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_word,
    output logic              sclk_o,
    output logic              sdata_o,
    output logic              fsync_o
);

    localparam int CNT_W = (DIV_W + 1 > GAP_W) ? DIV_W + 1 : GAP_W;

    logic             tmr_load, tmr_done;
    logic [CNT_W-1:0] tmr_val;
    logic             sh_load, sh_shift, sh_msb;
    logic             fs_act, sclk;
    logic [WORD_W-1:0] wire_word;

    assign wire_word = fsw_wire_order(fsw_word_t'(in_word), cfg_lsb_first);

    fsw_ctrl #(
        .DIV_W (DIV_W),
        .GAP_W (GAP_W),
        .CNT_W (CNT_W)
    ) ctrl_i (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .cfg_half  (cfg_half),
        .cfg_gap   (cfg_gap),
        .cfg_split (cfg_split),
        .tmr_done  (tmr_done),
        .tmr_load  (tmr_load),
        .tmr_val   (tmr_val),
        .sh_load   (sh_load),
        .sh_shift  (sh_shift),
        .fs_act    (fs_act),
        .sclk      (sclk)
    );

    fsw_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (tmr_done)
    );

    fsw_shifter #(
        .W (WORD_W)
    ) shifter_i (
        .clk       (clk),
        .rst       (rst),
        .load      (sh_load),
        .load_word (wire_word),
        .shift     (sh_shift),
        .msb       (sh_msb)
    );

    assign sclk_o  = sclk;
    assign sdata_o = fs_act & sh_msb;
    assign fsync_o = ~fs_act ^ cfg_fs_inv;

endmodule

// File: rtl/fsw_chk.sv
module fsw_chk (
    input logic clk,
    input logic rst,
    input logic cfg_fs_inv,
    input logic in_ready,
    input logic sclk_o,
    input logic sdata_o,
    input logic fsync_o
);

    logic       fa, fa_q, sclk_q;
    logic [4:0] falls;

    assign fa = (fsync_o == cfg_fs_inv);

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q   <= 1'b0;
            sclk_q <= 1'b1;
            falls  <= '0;
        end else begin
            fa_q   <= fa;
            sclk_q <= sclk_o;
            if (!fa) begin
                falls <= '0;
            end else if (sclk_q && !sclk_o) begin
                falls <= falls + 5'd1;
            end
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk)
        rst |=> (in_ready && sclk_o && !sdata_o && !fa));

    // R2
    release_count_chk: assert property (@(posedge clk) disable iff (rst)
        (fa_q && !fa) |-> (falls == 5'd16));

    // R2
    fall_bound_chk: assert property (@(posedge clk) disable iff (rst)
        falls <= 5'd16);

    // R5
    data_hold_low_chk: assert property (@(posedge clk) disable iff (rst)
        (!sclk_o && !sclk_q) |-> $stable(sdata_o));

    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        !fa |-> (sclk_o && !sdata_o));

    // R9
    ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
        in_ready |-> !fa);

endmodule

bind fsync_word_tx fsw_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .cfg_fs_inv (cfg_fs_inv),
    .in_ready   (in_ready),
    .sclk_o     (sclk_o),
    .sdata_o    (sdata_o),
    .fsync_o    (fsync_o)
);

// File: tb/fsync_word_tx_tb_top.sv
module fsync_word_tx_tb_top;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [15:0] w;
        logic        split;
        logic        lsb;
        logic        inv;
        logic [7:0]  half;
        logic [7:0]  gap;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{16'hA5C3, 1'b0, 1'b0, 1'b0, 8'd2, 8'd0},
        '{16'h2F81, 1'b1, 1'b0, 1'b0, 8'd1, 8'd5},
        '{16'h8001, 1'b0, 1'b1, 1'b0, 8'd3, 8'd0},
        '{16'h1234, 1'b1, 1'b1, 1'b1, 8'd2, 8'd1},
        '{16'hFFFF, 1'b0, 1'b0, 1'b1, 8'd1, 8'd0},
        '{16'h0000, 1'b1, 1'b0, 1'b0, 8'd4, 8'd0},
        '{16'h6C39, 1'b0, 1'b1, 1'b1, 8'd5, 8'd0},
        '{16'hC0DE, 1'b1, 1'b0, 1'b1, 8'd1, 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_half = 8'd2;
    logic [7:0]  cfg_gap = 8'd0;
    logic        cfg_split = 1'b0;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_fs_inv = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_word = 16'h0;
    logic        sclk_o, sdata_o, fsync_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fsync_word_tx dut_i (
        .clk           (clk),
        .rst           (rst),
        .cfg_half      (cfg_half),
        .cfg_gap       (cfg_gap),
        .cfg_split     (cfg_split),
        .cfg_lsb_first (cfg_lsb_first),
        .cfg_fs_inv    (cfg_fs_inv),
        .in_valid      (in_valid),
        .in_ready      (in_ready),
        .in_word       (in_word),
        .sclk_o        (sclk_o),
        .sdata_o       (sdata_o),
        .fsync_o       (fsync_o)
    );

    // Wire decoder, sampled between edges.
    int          cur_h = 1;
    logic        fa, prev_fa, prev_sclk, prev_sdata;
    int          falls, hi_run, low_run, lead, gaphi;
    int          hi_bad, lo_bad, viol, busy_bad, idle_bad;
    int          idle_run, last_idle;
    logic [15:0] rxw;

    always @(negedge clk) begin
        fa = (fsync_o == cfg_fs_inv);
        if (rst) begin
            prev_fa = 1'b0; prev_sclk = 1'b1; prev_sdata = 1'b0;
            idle_run = 0; last_idle = 0;
        end else begin
            if (fa && !prev_fa) begin
                last_idle = idle_run; idle_run = 0;
                falls = 0; rxw = '0; hi_run = 0; low_run = 0;
                lead = -1; gaphi = -1; hi_bad = 0; lo_bad = 0;
                viol = 0; busy_bad = 0;
            end
            if (!fa) begin
                idle_run++;
                if (!sclk_o || sdata_o) idle_bad++;
            end else begin
                if (in_ready) busy_bad++;
                if (prev_sclk && !sclk_o) begin
                    falls++;
                    rxw = {rxw[14:0], sdata_o};
                    if (falls == 1) lead = hi_run;
                    else if (falls == 9) gaphi = hi_run;
                    else if (hi_run != cur_h) hi_bad++;
                    hi_run = 0;
                end
                if (!prev_sclk && sclk_o) begin
                    if (low_run != cur_h) lo_bad++;
                    low_run = 0;
                end
                if (sclk_o) hi_run++; else low_run++;
                if (!sclk_o && !prev_sclk && sdata_o != prev_sdata) viol++;
            end
            prev_fa = fa; prev_sclk = sclk_o; prev_sdata = sdata_o;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    function automatic logic [7:0] mir(input logic [7:0] b);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = b[7-i];
        return r;
    endfunction

    task automatic run_frame(input vec_t v);
        @(negedge clk); #1;
        cfg_half = v.half; cfg_gap = v.gap; cfg_split = v.split;
        cfg_lsb_first = v.lsb; cfg_fs_inv = v.inv;
        in_word = v.w; in_valid = 1'b1;
        cur_h = (v.half == 8'd0) ? 1 : int'(v.half);
        idle_bad = 0;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        #1;
    endtask

    task automatic check_frame(input vec_t v);
        logic [15:0] exp_w;
        int          exp_gap;
        exp_w   = v.lsb ? {mir(v.w[15:8]), mir(v.w[7:0])} : v.w;
        exp_gap = (v.split && v.gap != 8'd0) ? int'(v.gap) + cur_h : cur_h;
        if (v.lsb) check(rxw == exp_w, "R7 mirrored bytes", int'(rxw), int'(exp_w));
        else       check(rxw == exp_w, "R3 msb-first word", int'(rxw), int'(exp_w));
        check(falls == 16, "R2 falls per frame", falls, 16);
        check(lead == cur_h, "R4 lead before first fall", lead, cur_h);
        check(hi_bad == 0 && lo_bad == 0, "R4 phase lengths", hi_bad + lo_bad, 0);
        check(viol == 0, "R5 data moved while low", viol, 0);
        check(gaphi == exp_gap, "R6 burst boundary high run", gaphi, exp_gap);
        check(busy_bad == 0, "R9 ready during frame", busy_bad, 0);
        check(idle_bad == 0, "R10 idle lines", idle_bad, 0);
        check(fsync_o == ~v.inv, "R8 idle frame-select level", int'(fsync_o), int'(~v.inv));
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        vec_t d;
        repeat (3) @(negedge clk);
        // R1: during reset
        check(in_ready && sclk_o && !sdata_o && fsync_o, "R1 state in reset",
              int'({in_ready, sclk_o, sdata_o, fsync_o}), 4'b1101);
        @(negedge clk); #1; rst = 1'b0;
        @(negedge clk);
        check(in_ready && sclk_o && !sdata_o && fsync_o, "R1 state after reset",
              int'({in_ready, sclk_o, sdata_o, fsync_o}), 4'b1101);

        for (int i = 0; i < NV; i++) begin
            run_frame(VEC[i]);
            check_frame(VEC[i]);
        end

        // R4: zero half-period acts as one
        d = '{16'h5A0F, 1'b0, 1'b0, 1'b0, 8'd0, 8'd0};
        run_frame(d);
        check_frame(d);

        // R8: inverted idle level, then restored
        @(negedge clk); #1; cfg_fs_inv = 1'b1;
        @(negedge clk);
        check(fsync_o == 1'b0, "R8 inverted idle", int'(fsync_o), 0);
        #1; cfg_fs_inv = 1'b0;
        @(negedge clk);
        check(fsync_o == 1'b1, "R8 normal idle", int'(fsync_o), 1);

        // R9: word offered the moment ready returns
        d = '{16'h3C3C, 1'b0, 1'b0, 1'b0, 8'd3, 8'd0};
        run_frame(d);
        in_word = 16'h9613; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        while (!in_ready) @(negedge clk);
        #1;
        check(last_idle >= 2 * cur_h, "R9 guard before next frame", last_idle, 2 * cur_h);
        check(rxw == 16'h9613, "R3 back-to-back word", int'(rxw), 16'h9613);

        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule